// File: doc/BRIEF.md
# Staggered Channel Enable Sequencer

This block drives the per-channel enable lines of a multi-channel current-sink driver. It computes a target vector from the latched per-channel on/off bits and a global blanking input: blanking forces every bit of the target to zero, and otherwise each bit follows its own on/off bit. The enable outputs do not all take the new target in the same clock. Channel 0 takes its new value first. Each higher channel follows one fixed step later. This spreads the switching events out in time and limits the supply inrush when many channels change at once.

The step is a parameter given in clock cycles. With the default of 4 cycles at 200 MHz, one step is 20 ns. Turning channels off uses the same ladder as turning them on. If the target changes while a ladder is still running, the ladder starts again from channel 0 with the new target. A channel the new ladder has not yet reached keeps the value it already has until the new ladder reaches it.

Top module: `stagger_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, every bit of `chan_en_o` is 0.
- R2: When the target changes, the clock edge that first samples the new target writes channel 0 with bit 0 of that target.
- R3: After that edge, channel n (for n from 1 to N_CH-1) takes bit n of the target exactly n*STEP_CYC clock cycles later. No channel changes at any other time.
- R4: While `blank_i` is 1, the target is all zeros, whatever `onoff_i` holds. No enable bit rises at a clock edge where `blank_i` is 1.
- R5: While `blank_i` is 0, bit n of the target equals `onoff_i[n]`.
- R6: Channels that switch from on to off follow the same staggered timing as channels that switch from off to on.
- R7: A change of the target during a ladder restarts the ladder from channel 0 with the new target. A channel the new ladder has not yet reached keeps its current value.
- R8: At most one enable bit changes at any clock edge.
- R9: When no ladder is running and the target is unchanged, `chan_en_o` equals the target and holds steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one step is STEP_CYC cycles of it |
| rst | input | 1 | Synchronous active-high reset |
| onoff_i | input | N_CH | Latched on/off bit per channel; bit n belongs to channel n |
| blank_i | input | 1 | 1 forces the target for every channel to off |
| chan_en_o | output | N_CH | Staggered enable per channel; bit n belongs to channel n |

## Verification
The hardest condition to reach is a restart that lands in the middle of a ladder. At that point some channels already hold the newer target, some still hold an older one, and the new ladder has to overwrite them in order. The stimulus produces this by changing `onoff_i` or `blank_i` a chosen number of cycles into a running ladder: just before a step boundary, on a step boundary, and several times in a row. A behavioural model counts cycles since the last restart and compares its result with the enables on every clock.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

    // Phase of the shared step timer
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } seq_phase_e;

    // Width needed to hold values 0..v-1, never less than one bit
    function automatic int unsigned width_for(input int unsigned v);
        int unsigned w;
        w = 1;
        while ((1 << w) < v) w++;
        return w;
    endfunction

endpackage

// File: rtl/stagger_timer.sv
module stagger_timer
    import stagger_pkg::*;
#(
    parameter int unsigned N_CH     = 16,
    parameter int unsigned STEP_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic            busy,
    output logic [N_CH-1:0] upd_sel
);
    localparam int unsigned IW = width_for(N_CH);
    localparam int unsigned TW = width_for(STEP_CYC);

    seq_phase_e    ph_q;
    logic [TW-1:0] tick_q;
    logic [IW-1:0] idx_q;
    logic          last_tick;

    assign last_tick = (tick_q == TW'(STEP_CYC - 1));
    assign busy      = (ph_q == PH_RUN);

    generate
        for (genvar n = 0; n < N_CH; n++) begin : g_sel
            if (n == 0) begin : g_first
                assign upd_sel[n] = start;
            end else begin : g_rest
                assign upd_sel[n] = !start && busy && last_tick
                                    && (int'(idx_q) + 1 == n);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            tick_q <= '0;
            idx_q  <= '0;
        end else if (start) begin
            ph_q   <= (N_CH > 1) ? PH_RUN : PH_IDLE;
            tick_q <= '0;
            idx_q  <= '0;
        end else if (busy) begin
            if (last_tick) begin
                tick_q <= '0;
                idx_q  <= idx_q + 1'b1;
                if (int'(idx_q) + 2 == N_CH) ph_q <= PH_IDLE;
            end else begin
                tick_q <= tick_q + 1'b1;
            end
        end
    end

    // R3
    tick_range_chk: assert property (@(posedge clk) disable iff (rst)
        tick_q <= TW'(STEP_CYC - 1));

    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd_sel));

    // R9
    idle_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tick_q == '0));

endmodule

// File: rtl/stagger_chan_bank.sv
module stagger_chan_bank #(
    parameter int unsigned N_CH = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] upd_sel,
    input  logic [N_CH-1:0] next_val,
    output logic [N_CH-1:0] en_q
);
    generate
        for (genvar n = 0; n < N_CH; n++) begin : g_ch
            always_ff @(posedge clk) begin
                if (rst)              en_q[n] <= 1'b0;
                else if (upd_sel[n])  en_q[n] <= next_val[n];
            end
        end
    endgenerate

    // R3
    only_selected_chk: assert property (@(posedge clk) disable iff (rst)
        ((en_q ^ $past(en_q)) & ~$past(upd_sel)) == '0);

endmodule

// File: rtl/stagger_seq.sv
module stagger_seq
    import stagger_pkg::*;
#(
    parameter int unsigned N_CH     = 16,
    parameter int unsigned STEP_CYC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] onoff_i,
    input  logic            blank_i,
    output logic [N_CH-1:0] chan_en_o
);
    logic [N_CH-1:0] target;
    logic [N_CH-1:0] snap_q;
    logic [N_CH-1:0] next_val;
    logic [N_CH-1:0] upd_sel;
    logic            start;
    logic            busy;

    assign target   = blank_i ? '0 : onoff_i;
    assign start    = !rst && (target != snap_q);
    assign next_val = start ? target : snap_q;

    always_ff @(posedge clk) begin
        if (rst)        snap_q <= '0;
        else if (start) snap_q <= target;
    end

    stagger_timer #(.N_CH(N_CH), .STEP_CYC(STEP_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .busy    (busy),
        .upd_sel (upd_sel)
    );

    stagger_chan_bank #(.N_CH(N_CH)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .upd_sel  (upd_sel),
        .next_val (next_val),
        .en_q     (chan_en_o)
    );

    // R4
    blank_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        blank_i |=> ((chan_en_o & ~$past(chan_en_o)) == '0));

    // R8
    single_change_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(chan_en_o ^ $past(chan_en_o)) <= 1);

    // R9
    idle_match_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |-> (chan_en_o == snap_q));

    // R2
    first_chan_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (chan_en_o[0] == $past(target[0])));

endmodule

// File: tb/stagger_seq_bench.sv
module stagger_seq_bench;
    localparam int N    = 16;
    localparam int STEP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  onoff = '0;
    logic          blank = 1'b0;
    logic [N-1:0]  en;

    int n_run  = 0;
    int n_fail = 0;
    int cyc_ct = 0;

    logic [N-1:0] ref_en   = '0;
    logic [N-1:0] ref_snap = '0;
    logic [N-1:0] prev_en  = '0;
    bit           ref_act  = 0;
    int           ref_cnt  = 0;

    always #2.5 clk = ~clk;

    stagger_seq #(.N_CH(N), .STEP_CYC(STEP)) u_stagger_seq (
        .clk       (clk),
        .rst       (rst),
        .onoff_i   (onoff),
        .blank_i   (blank),
        .chan_en_o (en)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc_ct);
        end
    endtask

    // Advance the behavioural model by one clock edge
    task automatic model_step();
        logic [N-1:0] tgt;
        tgt = blank ? '0 : onoff;
        if (tgt != ref_snap) begin
            ref_snap  = tgt;
            ref_cnt   = 0;
            ref_en[0] = tgt[0];
            ref_act   = (N > 1);
        end else if (ref_act) begin
            ref_cnt++;
            if (ref_cnt % STEP == 0) begin
                ref_en[ref_cnt / STEP] = ref_snap[ref_cnt / STEP];
                if (ref_cnt / STEP == N - 1) ref_act = 0;
            end
        end
    endtask

    // Called at a falling edge: drive, step model, wait one clock, compare
    task automatic cyc(input logic [N-1:0] oo, input logic bl, input string tag);
        onoff = oo;
        blank = bl;
        model_step();
        prev_en = en;
        @(negedge clk);
        cyc_ct++;
        check(en == ref_en, tag, en, ref_en);
        check($countones(en ^ prev_en) <= 1, "R8", en ^ prev_en, '0);
    endtask

    task automatic hold(input int k, input string tag);
        for (int i = 0; i < k; i++) cyc(onoff, blank, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(en == '0, "R1", en, '0);
        rst = 1'b0;
        @(negedge clk);
        check(en == '0, "R1", en, '0);

        // All channels on from all off
        cyc(16'hFFFF, 1'b0, "R2");
        check(en == 16'h0001, "R2", en, 16'h0001);
        hold(STEP, "R3");
        check(en == 16'h0003, "R3", en, 16'h0003);
        hold(STEP * (N - 2), "R3");
        check(en == 16'hFFFF, "R3", en, 16'hFFFF);
        hold(6, "R9");
        check(en == 16'hFFFF, "R9", en, 16'hFFFF);

        // Mixed pattern: some channels turn off along the ladder
        cyc(16'hA5C3, 1'b0, "R6");
        hold(STEP * 3, "R6");
        check(en == 16'hFFF3, "R6", en, 16'hFFF3);
        hold(STEP * (N - 3) + 4, "R5");
        check(en == 16'hA5C3, "R5", en, 16'hA5C3);

        // Blank in the middle of a ladder, with on/off bits still set
        cyc(16'h5A3C, 1'b0, "R7");
        hold(STEP * 5 + 2, "R7");
        cyc(16'h5A3C, 1'b1, "R4");
        hold(STEP * N + 3, "R4");
        check(en == '0, "R4", en, '0);
        cyc(16'hFFFF, 1'b1, "R4");
        hold(STEP * 2, "R4");
        check(en == '0, "R4", en, '0);

        // Release blank: target follows on/off bits again
        cyc(16'h0F0F, 1'b0, "R5");
        hold(STEP * N, "R5");
        check(en == 16'h0F0F, "R5", en, 16'h0F0F);

        // Repeated restarts at various offsets inside a ladder
        cyc(16'hF0F0, 1'b0, "R7");
        hold(STEP - 2, "R7");
        cyc(16'h3333, 1'b0, "R7");
        hold(STEP * 4 - 1, "R7");
        cyc(16'hCCCC, 1'b0, "R7");
        hold(STEP * 7, "R7");
        cyc(16'h1248, 1'b0, "R7");
        cyc(16'h8421, 1'b0, "R7");
        hold(STEP * N + 2, "R9");
        check(en == 16'h8421, "R9", en, 16'h8421);

        // All off
        cyc(16'h0000, 1'b0, "R6");
        hold(STEP * N, "R6");
        check(en == '0, "R6", en, '0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule